// File: doc/BRIEF.md
# Loopback Self-Test Pattern Generator

This block feeds a serial link's loopback self-test with an unbroken stream of test words. A 2-bit code picks one of four patterns. Three of them repeat fixed characters. These are handed out as bytes with a per-byte control flag, ready for an 8b/10b encoder further down the path. The fourth is a counting pattern: the same 16-bit count sits in both halves of each 32-bit word.

Each output word carries four characters, least significant byte first, with one control flag per byte lane. Words leave through a valid/ready handshake. The enable input gates the stream. While it is low no word is offered and the count returns to zero, so every new run of the counting pattern starts at 0000_0000.

Top module: `lbk_pattern_gen`

## Requirements
- R1: Code 00 gives the word A2A2A2A2h (the D2.5 character in every lane) with all four control flags clear.
- R2: Code 01 gives the word 78787878h (the D24.3 character in every lane) with all four control flags clear.
- R3: Code 10 gives the word BC4A4A4Ah: lanes 0 to 2 hold D10.2 (4Ah) and lane 3 holds K28.5 (BCh). The control flags read 4'b1000, so only lane 3 is flagged.
- R4: Code 11 gives a word whose bits [31:16] and [15:0] both equal the current count, with all control flags clear.
- R5: The count rises by one for each word accepted under code 11. After FFFF_FFFFh it wraps to 0000_0000h and keeps counting.
- R6: out_valid is low during reset and while the block is disabled. It goes high one cycle after gen_en is sampled high and low one cycle after gen_en is sampled low.
- R7: While out_valid is high and out_ready is low, the count holds and the word does not change.
- R8: Sampling gen_en low clears the count, so the first word of a new counting run is 0000_0000h.
- R9: The count changes only on words accepted under code 11. Running the other codes leaves the count where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_sel | input | 2 | Pattern code |
| gen_en | input | 1 | Generator enable |
| out_ready | input | 1 | Consumer accepts the word when high |
| out_valid | output | 1 | A word is offered |
| out_data | output | 32 | Four characters, lane 0 in bits [7:0] |
| out_kflag | output | 4 | Control-character flag per byte lane |

## Verification
The word and control flags follow pat_sel in the same cycle. The count and out_valid change one clock edge after the enable or handshake that causes them. The bench drives its inputs at the falling edge and compares every output before the next rising edge. Its model folds the handshake and enable into the count and valid state only at that rising edge, so each compare sees exactly one register step of delay. The counting run goes past a full pass of 65536 words, which shows the wrap in the cycle it falls due.

// File: rtl/lbk_pattern_gen.sv
module lbk_pattern_gen #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pat_sel,
  input  logic                gen_en,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [2*HALF_W-1:0] out_data,
  output logic [3:0]          out_kflag
);
  localparam logic [7:0] CH_D2_5  = 8'hA2;
  localparam logic [7:0] CH_D24_3 = 8'h78;
  localparam logic [7:0] CH_D10_2 = 8'h4A;
  localparam logic [7:0] CH_K28_5 = 8'hBC;

  logic [HALF_W-1:0] count_q;
  logic              valid_q;
  logic              fire;

  assign fire      = valid_q && out_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      count_q <= '0;
    end else begin
      valid_q <= gen_en;
      if (!gen_en)
        count_q <= '0;
      else if (fire && pat_sel == 2'b11)
        count_q <= count_q + 1'b1;
    end
  end

  always_comb begin
    out_kflag = 4'b0000;
    unique case (pat_sel)
      2'b00: out_data = {4{CH_D2_5}};
      2'b01: out_data = {4{CH_D24_3}};
      2'b10: begin
        out_data  = {CH_K28_5, {3{CH_D10_2}}};
        out_kflag = 4'b1000;
      end
      default: out_data = {count_q, count_q};
    endcase
  end

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !out_valid); // R6
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |=> out_valid); // R6
  AST_HALVES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pat_sel == 2'b11) |-> (out_data[31:16] == out_data[15:0])); // R4
  AST_KFLAG_LANE3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kflag == ((pat_sel == 2'b10) ? 4'b1000 : 4'b0000))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gen_en && pat_sel == 2'b11) |=>
      (!gen_en || pat_sel != 2'b11 || out_data[15:0] == $past(out_data[15:0]) + 16'd1)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && gen_en) |=>
      (!gen_en || !$stable(pat_sel) || $stable(out_data))); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && pat_sel == 2'b11) |-> (out_data == '0)); // R8
endmodule

// File: tb/test_lbk_pattern_gen.sv
module test_lbk_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pat_sel = 2'b00;
  logic        gen_en = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_kflag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int m_count = 0;
  bit m_valid = 0;

  lbk_pattern_gen i_lbk_pattern_gen (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .gen_en(gen_en),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_kflag(out_kflag)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag);
    logic [31:0] ed;
    logic [3:0]  ek;
    string       t;
    ek = 4'b0000;
    case (pat_sel)
      2'b00: begin ed = 32'hA2A2A2A2; t = "R1"; end
      2'b01: begin ed = 32'h78787878; t = "R2"; end
      2'b10: begin ed = 32'hBC4A4A4A; ek = 4'b1000; t = "R3"; end
      default: begin ed = {m_count[15:0], m_count[15:0]}; t = "R4/R5"; end
    endcase
    if (tag != "") t = tag;
    checks++;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL R6 (%s) out_valid actual %0b expected %0b", t, out_valid, m_valid);
    end else if (m_valid && (out_data !== ed || out_kflag !== ek)) begin
      errors++;
      $display("FAIL %s data/kflag actual %h/%b expected %h/%b", t, out_data, out_kflag, ed, ek);
    end
  endtask

  task automatic cyc(input bit en, input logic [1:0] pat, input bit rdy, input string tag);
    gen_en = en; pat_sel = pat; out_ready = rdy;
    #1 check(tag);
    @(posedge clk);
    if (!en) m_count = 0;
    else if (m_valid && rdy && pat == 2'b11) m_count = (m_count + 1) % 65536;
    m_valid = en;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) cyc(1, 2'b00, 1, "");
    for (int i = 0; i < 4; i++) cyc(1, 2'b01, i[0], "");
    for (int i = 0; i < 4; i++) cyc(1, 2'b10, 1, "");
    cyc(0, 2'b11, 1, "R6");
    cyc(0, 2'b11, 1, "R6");
    for (int i = 0; i < 10; i++) cyc(1, 2'b11, 1, "R5");
    for (int i = 0; i < 5; i++) cyc(1, 2'b11, 0, "R7");
    for (int i = 0; i < 4; i++) cyc(1, 2'b01, 1, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 2'b11, 1, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 2'b11, i != 1, "R7");
    cyc(0, 2'b11, 1, "R8");
    cyc(0, 2'b11, 1, "R8");
    for (int i = 0; i < 65545; i++) cyc(1, 2'b11, 1, "R5 wrap");
    cyc(1, 2'b10, 0, "R3");
    cyc(1, 2'b00, 1, "R1");
    cyc(0, 2'b00, 1, "R6");
    cyc(0, 2'b00, 1, "R6");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule